// File: doc/BRIEF.md
# Vectored Interrupt Acknowledge Controller

This block sits between a device's internal interrupt request and a shared processor bus. It handles the acknowledge cycle that follows an interrupt request. It raises a gated interrupt line and follows the acknowledge strobe, which arrives as either one pulse or a pair of pulses. It then decides whether this device is the one being acknowledged. If it is, it places an 8-bit vector on the data bus during the pulse that completes the acknowledge.

The block has two cascading modes.

- **Slave mode:** the acknowledge targets this device only when a 3-bit code on the enable lines matches a programmed slave address.
- **Chain mode:** the devices form a priority chain. One enable line comes in from the upstream device and an enable output goes to the downstream device. A device with its own interrupt active blocks the chain for everything below it.

The gated interrupt line never rises while an acknowledge is in progress. A request that arrives during the sequence is held back and raised as soon as the sequence finishes. All inputs are sampled on the rising clock edge, and reset is synchronous and active high.

Top module: `irq_ack_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, irq_out, data_oe and data_out are all 0.
- R2: When no acknowledge is in progress, irq_out takes the value of irq_req one clock later, and it falls one clock after irq_req falls.
- R3: irq_out never changes from 0 to 1 in any of these cases: while ack_strobe is high, between the pulses of a two-pulse sequence, or on the clock that ends a sequence.
- R4: A request held back by R3 raises irq_out on the second clock after the falling strobe edge that ends the sequence.
- R5: With two_pulse=0, one strobe pulse completes the acknowledge. On acceptance, data_oe is 1 and data_out equals the vector. This lasts from the clock that samples the strobe high until the clock that samples it low.
- R6: With two_pulse=1, the sequence takes two strobe pulses. data_oe stays 0 during the first pulse and the gap between the pulses. On acceptance, the vector is driven only during the second pulse.
- R7: With chain_mode=0 (slave mode), the acknowledge is accepted only if en_in equals slave_addr. The comparison is made on the clock that samples the start of the final pulse.
- R8: With chain_mode=1 (chain mode), the acknowledge is accepted only if both of these hold:
  - en_in[1] is 1 at the start of the final pulse;
  - irq_out was 1 on the clock that began the sequence.
  In this mode en_in[0] and en_in[2] have no effect.
- R9: In chain mode, chain_out equals en_in[1] AND NOT irq_out, with no clock delay. In slave mode, chain_out is 0.
- R10: data_out is all zeros whenever data_oe is 0, including after an acknowledge that is refused.
- R11: The vector is captured when the final pulse starts. Changes to the vector input during the pulse do not change data_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_req | input | 1 | Internal interrupt request of the device |
| ack_strobe | input | 1 | Acknowledge strobe, active high |
| two_pulse | input | 1 | 1 = two-pulse acknowledge, 0 = single pulse |
| chain_mode | input | 1 | 1 = chain cascading, 0 = slave-address cascading |
| en_in | input | 3 | Enable lines; slave code, or bit 1 = chain enable in |
| slave_addr | input | 3 | Programmed slave address |
| vector | input | 8 | Vector value to return on acceptance |
| irq_out | output | 1 | Gated interrupt request line |
| data_out | output | 8 | Vector driven toward the data bus |
| data_oe | output | 1 | Output enable of the data bus |
| chain_out | output | 1 | Chain enable output to the downstream device |

## Verification
The assertions assume the following about the block's inputs:
- two_pulse and chain_mode stay fixed from the first strobe edge of a sequence until it ends;
- every strobe high phase and low phase lasts at least one clock, so the edge detector sees each one.

The stimulus changes modes and table entries only while the sequencer is idle. It holds each strobe level for two clocks, and it changes the vector and enable inputs only on the falling clock edge. The transition checks on the sequencer and the stability check on the vector therefore see the intended sequences and nothing else.

// File: rtl/iack_pkg.sv
package iack_pkg;

    localparam int VEC_W  = 8;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_FIRST = 2'd1,
        SEQ_GAP   = 2'd2,
        SEQ_FINAL = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } strobe_edge_t;

    typedef struct packed {
        logic start;      // first strobe edge of a sequence
        logic final_go;   // final pulse begins
        logic done;       // final pulse ends
    } seq_event_t;

    function automatic logic code_match(input logic [CODE_W-1:0] a,
                                        input logic [CODE_W-1:0] b);
        return a == b;
    endfunction

endpackage

// File: rtl/iack_seq.sv
module iack_seq
    import iack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       strobe,
    input  logic       two_pulse,
    output seq_state_e state,
    output seq_event_t ev
);
    logic         strobe_q;
    strobe_edge_t edg;
    seq_state_e   state_nx;

    always_comb begin
        edg.rise = strobe & ~strobe_q;
        edg.fall = ~strobe & strobe_q;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SEQ_IDLE:  if (edg.rise) state_nx = two_pulse ? SEQ_FIRST : SEQ_FINAL;
            SEQ_FIRST: if (edg.fall) state_nx = SEQ_GAP;
            SEQ_GAP:   if (edg.rise) state_nx = SEQ_FINAL;
            SEQ_FINAL: if (edg.fall) state_nx = SEQ_IDLE;
            default:   state_nx = SEQ_IDLE;
        endcase
    end

    always_comb begin
        ev.start    = (state == SEQ_IDLE) & edg.rise;
        ev.final_go = edg.rise & (((state == SEQ_IDLE) & ~two_pulse) | (state == SEQ_GAP));
        ev.done     = (state == SEQ_FINAL) & edg.fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b0;
            state    <= SEQ_IDLE;
        end else begin
            strobe_q <= strobe;
            state    <= state_nx;
        end
    end

    // R6
    first_leg_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_FIRST) |=> (state == SEQ_FIRST || state == SEQ_GAP));

    // R6
    gap_leg_chk: assert property (@(posedge clk) disable iff (rst)
        (state == SEQ_GAP) |=> (state == SEQ_GAP || state == SEQ_FINAL));

endmodule

// File: rtl/iack_irq_gate.sv
module iack_irq_gate (
    input  logic clk,
    input  logic rst,
    input  logic irq_req,
    input  logic block,
    output logic irq_q
);
    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_req & (irq_q | ~block);
    end

    // R3
    no_new_irq_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> !$past(block));

    // R2
    irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_req |=> !irq_q);

endmodule

// File: rtl/iack_accept.sv
module iack_accept
    import iack_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  seq_event_t    ev,
    input  logic          chain_mode,
    input  logic [CW-1:0] en_in,
    input  logic [CW-1:0] slave_addr,
    input  logic [VW-1:0] vector,
    input  logic          irq_active,
    output logic          granted,
    output logic [VW-1:0] vec_q
);
    logic own_req_q;
    logic own_req_now;
    logic hit;

    assign own_req_now = ev.start ? irq_active : own_req_q;

    generate
        if (CW > 1) begin : g_chain_sel
            always_comb begin
                if (chain_mode) hit = en_in[1] & own_req_now;
                else            hit = code_match(en_in, slave_addr);
            end
        end else begin : g_slave_only
            always_comb hit = code_match(en_in, slave_addr);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            own_req_q <= 1'b0;
            granted   <= 1'b0;
            vec_q     <= '0;
        end else begin
            if (ev.start) own_req_q <= irq_active;
            if (ev.done) begin
                granted <= 1'b0;
            end else if (ev.final_go) begin
                granted <= hit;
                vec_q   <= vector;
            end
        end
    end

    // R11
    vec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (granted && !ev.done && !ev.final_go) |=> $stable(vec_q));

endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl
    import iack_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int CW = CODE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          irq_req,
    input  logic          ack_strobe,
    input  logic          two_pulse,
    input  logic          chain_mode,
    input  logic [CW-1:0] en_in,
    input  logic [CW-1:0] slave_addr,
    input  logic [VW-1:0] vector,
    output logic          irq_out,
    output logic [VW-1:0] data_out,
    output logic          data_oe,
    output logic          chain_out
);
    seq_state_e    seq_state;
    seq_event_t    seq_ev;
    logic          irq_block;
    logic          granted;
    logic [VW-1:0] vec_q;

    iack_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .strobe    (ack_strobe),
        .two_pulse (two_pulse),
        .state     (seq_state),
        .ev        (seq_ev)
    );

    assign irq_block = (seq_state != SEQ_IDLE) | ack_strobe;

    iack_irq_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .irq_req (irq_req),
        .block   (irq_block),
        .irq_q   (irq_out)
    );

    iack_accept #(.VW(VW), .CW(CW)) u_accept (
        .clk        (clk),
        .rst        (rst),
        .ev         (seq_ev),
        .chain_mode (chain_mode),
        .en_in      (en_in),
        .slave_addr (slave_addr),
        .vector     (vector),
        .irq_active (irq_out),
        .granted    (granted),
        .vec_q      (vec_q)
    );

    assign data_oe = granted;

    generate
        for (genvar b = 0; b < VW; b++) begin : g_bus
            assign data_out[b] = vec_q[b] & granted;
        end
        if (CW > 1) begin : g_chain_out
            assign chain_out = chain_mode & en_in[1] & ~irq_out;
        end else begin : g_no_chain
            assign chain_out = 1'b0;
        end
    endgenerate

    // R5
    oe_in_final_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> (seq_state == SEQ_FINAL));

    // R9
    chain_block_chk: assert property (@(posedge clk) disable iff (rst)
        (chain_mode && irq_out) |-> !chain_out);

    // R11
    bus_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

endmodule

// File: tb/test_irq_ack_ctrl.sv
module test_irq_ack_ctrl;

    typedef struct packed {
        logic       tp;
        logic       chain;
        logic [2:0] en;
        logic [2:0] addr;
        logic       irq;
        logic [7:0] vec;
        logic       acc;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t TABLE [NV] = '{
        '{1'b0, 1'b0, 3'b101, 3'b101, 1'b1, 8'hA5, 1'b1},
        '{1'b0, 1'b0, 3'b100, 3'b101, 1'b1, 8'h3C, 1'b0},
        '{1'b1, 1'b0, 3'b011, 3'b011, 1'b0, 8'h81, 1'b1},
        '{1'b1, 1'b0, 3'b111, 3'b110, 1'b1, 8'h42, 1'b0},
        '{1'b0, 1'b1, 3'b010, 3'b000, 1'b1, 8'h5A, 1'b1},
        '{1'b0, 1'b1, 3'b101, 3'b101, 1'b1, 8'h66, 1'b0},
        '{1'b1, 1'b1, 3'b111, 3'b000, 1'b0, 8'h99, 1'b0},
        '{1'b1, 1'b1, 3'b111, 3'b000, 1'b1, 8'hF0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_req = 1'b0;
    logic       ack_strobe = 1'b0;
    logic       two_pulse = 1'b0;
    logic       chain_mode = 1'b0;
    logic [2:0] en_in = '0;
    logic [2:0] slave_addr = '0;
    logic [7:0] vector = '0;
    logic       irq_out;
    logic [7:0] data_out;
    logic       data_oe;
    logic       chain_out;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_ack_ctrl i_irq_ack_ctrl (
        .clk(clk), .rst(rst), .irq_req(irq_req), .ack_strobe(ack_strobe),
        .two_pulse(two_pulse), .chain_mode(chain_mode), .en_in(en_in),
        .slave_addr(slave_addr), .vector(vector), .irq_out(irq_out),
        .data_out(data_out), .data_oe(data_oe), .chain_out(chain_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        step(3);
        chk("R1 irq_out", irq_out, 0);
        chk("R1 data_oe", data_oe, 0);
        rst = 1'b0;
        step(1);
        chk("R1 data_out", data_out, 0);
        chk("R1 data_oe after", data_oe, 0);

        // R2 plain request path
        irq_req = 1'b1; step(1);
        chk("R2 rise", irq_out, 1);
        irq_req = 1'b0; step(1);
        chk("R2 fall", irq_out, 0);

        // Table walk: R5, R6, R7, R8, R9, R10
        for (int i = 0; i < NV; i++) begin
            two_pulse  = TABLE[i].tp;
            chain_mode = TABLE[i].chain;
            en_in      = TABLE[i].en;
            slave_addr = TABLE[i].addr;
            vector     = TABLE[i].vec;
            irq_req    = TABLE[i].irq;
            step(2);
            chk("R9 chain_out", chain_out, TABLE[i].chain & TABLE[i].en[1] & ~TABLE[i].irq);
            if (TABLE[i].tp) begin
                ack_strobe = 1'b1; step(1);
                chk("R6 first pulse oe", data_oe, 0);
                step(1);
                ack_strobe = 1'b0; step(1);
                chk("R6 gap oe", data_oe, 0);
                step(1);
            end
            ack_strobe = 1'b1; step(1);
            chk(TABLE[i].chain ? "R8 accept" : "R7 accept", data_oe, TABLE[i].acc);
            chk("R5 vector / R10 zero", data_out, TABLE[i].acc ? TABLE[i].vec : 8'h00);
            step(1);
            ack_strobe = 1'b0; step(1);
            chk("R5 oe released", data_oe, 0);
            chk("R10 bus zero", data_out, 0);
            irq_req = 1'b0; step(2);
        end

        // R3 and R4: single-pulse blocking
        two_pulse = 1'b0; chain_mode = 1'b0; en_in = 3'b001; slave_addr = 3'b001;
        vector = 8'h17; step(1);
        ack_strobe = 1'b1; step(1);
        irq_req = 1'b1; step(2);
        chk("R3 blocked in pulse", irq_out, 0);
        // R11 vector change during pulse
        vector = 8'hEE; step(1);
        chk("R11 vector held", data_out, 8'h17);
        ack_strobe = 1'b0; step(1);
        chk("R3 blocked at end", irq_out, 0);
        step(1);
        chk("R4 release", irq_out, 1);
        irq_req = 1'b0; step(2);

        // R3 and R4: two-pulse gap blocking
        two_pulse = 1'b1;
        ack_strobe = 1'b1; step(2);
        ack_strobe = 1'b0; step(1);
        irq_req = 1'b1; step(2);
        chk("R3 blocked in gap", irq_out, 0);
        ack_strobe = 1'b1; step(1);
        chk("R6 second pulse oe", data_oe, 1);
        chk("R3 blocked second", irq_out, 0);
        step(1);
        ack_strobe = 1'b0; step(1);
        chk("R3 blocked end two", irq_out, 0);
        step(1);
        chk("R4 release two", irq_out, 1);

        // R9 slave mode and chain block
        chain_mode = 1'b0; en_in = 3'b010; step(1);
        chk("R9 slave zero", chain_out, 0);
        chain_mode = 1'b1; step(1);
        chk("R9 own irq blocks", chain_out, 0);
        irq_req = 1'b0; step(1);
        chk("R9 pass through", chain_out, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule